// File: doc/BRIEF.md
# Byte-Serial Long-Instruction Fetch Unit

This unit feeds a three-slot long-instruction pipeline from an instruction memory that is only one byte wide. Each pipeline stage lasts three clock cycles. In each of those cycles the unit drives one byte address and captures the byte that the memory returns later in the same cycle. At the end of the stage it has gathered three bytes, and it hands decode one 24-bit instruction word together with a one-cycle valid pulse.

The unit keeps a program counter that counts bytes, not instructions. Inside a stage the counter steps by one each cycle. At a stage boundary it either keeps going in sequence or jumps to a target from the execute stage. The target arrives as an instruction index, and the unit turns it into a byte address by multiplying by the word size. Because the two instruction slots after a branch always execute, a redirect never cancels a word that is already in flight. It only changes where the next stage starts reading.

Top module: `vliw_byte_fetch`

## Requirements
- R1: While reset is asserted, imem_addr is 0, ifd_valid is 0 and ifd_word is 0. After release, the first stage reads bytes 0, 1 and 2, starting in its first cycle.
- R2: Exactly one byte address is driven per cycle. Within a stage, the address in cycle k (k = 0, 1, 2) is the stage start address plus k.
- R3: The byte read in the first cycle of a stage lands in ifd_word bits 23:16. The second lands in bits 15:8 and the third in bits 7:0.
- R4: ifd_valid is high for exactly one cycle: the cycle after the third byte of a stage is captured. It is low in the other two cycles of each stage.
- R5: ifd_word keeps its value in every cycle in which ifd_valid is low.
- R6: When redir_valid is high in the third cycle of a stage, the next stage starts at byte address (3 × redir_index) mod 256.
- R7: redir_valid or redir_index applied in the first or second cycle of a stage has no effect on any address or word.
- R8: A redirect never cancels the word being assembled; that word is still delivered intact. Without a redirect, the next stage starts three bytes after the current one.
- R9: The byte program counter wraps from 255 to 0, and targets whose product exceeds 255 are taken modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 8 | Byte address driven to the instruction memory this cycle |
| imem_rdata | input | 8 | Byte returned by the memory for imem_addr in the same cycle |
| redir_valid | input | 1 | Redirect request from execute, sampled in a stage's third cycle |
| redir_index | input | 8 | Target instruction index for the redirect |
| ifd_word | output | 24 | Assembled instruction word for decode |
| ifd_valid | output | 1 | One-cycle pulse marking a newly assembled word |

## Verification
The bench targets several places where this unit can go wrong. Redirects are placed in the last cycle of a stage, and spurious redirect requests are placed in the first two cycles. A design that samples at the wrong phase would either jump one stage early or lose the branch. Back-to-back redirects, a target at index 0, and a target of index 255 (byte 253) check the delay-slot rule and the modulo arithmetic. The last of these is followed by a sequential step that must wrap to address 0. A design that used an instruction counter, or that did not truncate, would fetch from the wrong place. A reset in mid-stage checks that the phase restarts, so that a stale byte-slot order cannot scramble the next word.

// File: rtl/vbf_pkg.sv
package vbf_pkg;

   // Width of a counter that holds the values 0 .. n-1 (at least one bit).
   function automatic int unsigned phase_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/vbf_phase_ctr.sv
module vbf_phase_ctr #(
   parameter int unsigned SLOTS   = 3,
   parameter int unsigned PHASE_W = vbf_pkg::phase_bits(SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PHASE_W-1:0] phase_q,
   output logic               stage_end
);

   localparam logic [PHASE_W-1:0] LAST = PHASE_W'(SLOTS - 1);

   assign stage_end = (phase_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (stage_end)
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end

endmodule

// File: rtl/vbf_pc_gen.sv
module vbf_pc_gen #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned SLOTS    = 3,
   parameter bit          SHIFT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_end,
   input  logic              redir_valid,
   input  logic [ADDR_W-1:0] redir_index,
   output logic [ADDR_W-1:0] pc_q
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SLOTS);

   logic [ADDR_W-1:0] target;

   generate
      if (SHIFT_ADD && SLOTS == 3) begin : g_times3
         assign target = (redir_index << 1) + redir_index;
      end else begin : g_mul
         assign target = redir_index * STEP;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc_q <= '0;
      else if (stage_end && redir_valid)
         pc_q <= target;
      else
         pc_q <= pc_q + 1'b1;
   end

endmodule

// File: rtl/vbf_assembler.sv
module vbf_assembler #(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned SLOTS   = 3,
   parameter int unsigned PHASE_W = vbf_pkg::phase_bits(SLOTS),
   parameter int unsigned WORD_W  = BYTE_W * SLOTS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] phase,
   input  logic               stage_end,
   input  logic [BYTE_W-1:0]  rdata,
   output logic [WORD_W-1:0]  word_q,
   output logic               valid_q
);

   localparam int unsigned HELD = SLOTS - 1;

   // Earlier phases sit in the upper bytes; the byte of the last phase
   // completes the word directly from the memory return.
   logic [HELD*BYTE_W-1:0] held_q;
   logic [WORD_W-1:0]      next_word;

   assign next_word = {held_q, rdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
      end else begin
         for (int k = 0; k < int'(HELD); k++) begin
            if (phase == PHASE_W'(k))
               held_q[(HELD-1-k)*BYTE_W +: BYTE_W] <= rdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= stage_end;
         if (stage_end)
            word_q <= next_word;
      end
   end

endmodule

// File: rtl/vliw_byte_fetch.sv
module vliw_byte_fetch #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned SLOTS     = 3,
   parameter bit          SHIFT_ADD = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   output logic [ADDR_W-1:0]         imem_addr,
   input  logic [BYTE_W-1:0]         imem_rdata,
   input  logic                      redir_valid,
   input  logic [ADDR_W-1:0]         redir_index,
   output logic [BYTE_W*SLOTS-1:0]   ifd_word,
   output logic                      ifd_valid
);

   localparam int unsigned WORD_W  = BYTE_W * SLOTS;
   localparam int unsigned PHASE_W = vbf_pkg::phase_bits(SLOTS);

   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("vliw_byte_fetch: SLOTS must be at least 2");
      end
      if (ADDR_W < 2 || BYTE_W < 1) begin : g_bad_width
         $error("vliw_byte_fetch: ADDR_W and BYTE_W out of range");
      end
   endgenerate

   logic [PHASE_W-1:0] phase_q;
   logic               stage_end;

   vbf_phase_ctr #(.SLOTS(SLOTS), .PHASE_W(PHASE_W)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_q   (phase_q),
      .stage_end (stage_end)
   );

   vbf_pc_gen #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .SHIFT_ADD(SHIFT_ADD)) u_pc (
      .clk         (clk),
      .rst_n       (rst_n),
      .stage_end   (stage_end),
      .redir_valid (redir_valid),
      .redir_index (redir_index),
      .pc_q        (imem_addr)
   );

   vbf_assembler #(.BYTE_W(BYTE_W), .SLOTS(SLOTS), .PHASE_W(PHASE_W),
                   .WORD_W(WORD_W)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase_q),
      .stage_end (stage_end),
      .rdata     (imem_rdata),
      .word_q    (ifd_word),
      .valid_q   (ifd_valid)
   );

endmodule

// File: rtl/vbf_checker.sv
module vbf_checker #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned SLOTS   = 3,
   parameter int unsigned PHASE_W = vbf_pkg::phase_bits(SLOTS)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [PHASE_W-1:0]      phase,
   input logic [ADDR_W-1:0]       imem_addr,
   input logic [BYTE_W-1:0]       imem_rdata,
   input logic                    redir_valid,
   input logic [ADDR_W-1:0]       redir_index,
   input logic [BYTE_W*SLOTS-1:0] ifd_word,
   input logic                    ifd_valid
);

   localparam logic [PHASE_W-1:0] LAST = PHASE_W'(SLOTS - 1);
   localparam logic [ADDR_W-1:0]  STEP = ADDR_W'(SLOTS);

   logic [ADDR_W-1:0] chk_target;
   assign chk_target = redir_index * STEP;

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != LAST) |=> (imem_addr == $past(imem_addr) + 1'b1));

   // R8
   seq_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == LAST && !redir_valid) |=> (imem_addr == $past(imem_addr) + 1'b1));

   // R6
   redir_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == LAST && redir_valid) |=> (imem_addr == $past(chk_target)));

   // R4
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == LAST) |=> ifd_valid);

   // R4
   valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != LAST) |=> !ifd_valid);

   // R5
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ifd_valid |-> $stable(ifd_word));

   // R3
   low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ifd_valid |-> (ifd_word[BYTE_W-1:0] == $past(imem_rdata)));

endmodule

bind vliw_byte_fetch vbf_checker #(
   .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .SLOTS(SLOTS), .PHASE_W(PHASE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .phase       (phase_q),
   .imem_addr   (imem_addr),
   .imem_rdata  (imem_rdata),
   .redir_valid (redir_valid),
   .redir_index (redir_index),
   .ifd_word    (ifd_word),
   .ifd_valid   (ifd_valid)
);

// File: tb/vliw_byte_fetch_tb.sv
module vliw_byte_fetch_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  imem_addr;
   logic [7:0]  imem_rdata;
   logic        redir_valid = 1'b0;
   logic [7:0]  redir_index = '0;
   logic [23:0] ifd_word;
   logic        ifd_valid;

   logic [7:0]  mem [0:255];

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0]  exp_start;
   logic [23:0] prev_word;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign imem_rdata = mem[imem_addr];

   vliw_byte_fetch u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .imem_addr   (imem_addr),
      .imem_rdata  (imem_rdata),
      .redir_valid (redir_valid),
      .redir_index (redir_index),
      .ifd_word    (ifd_word),
      .ifd_valid   (ifd_valid)
   );

   function automatic logic [23:0] exp_word(input logic [7:0] s);
      return {mem[s], mem[8'(s + 8'd1)], mem[8'(s + 8'd2)]};
   endfunction

   function automatic logic [7:0] tgt(input logic [7:0] idx);
      return 8'((32'(idx) * 3) % 256);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One full stage starting at a falling edge with the unit in its first phase.
   task automatic run_stage(input bit redir, input logic [7:0] idx,
                            input bit spur, input logic [7:0] spur_idx);
      logic [7:0] s;
      s = exp_start;
      for (int c = 0; c < 3; c++) begin
         redir_valid = (c == 2) ? redir : spur;
         redir_index = (c == 2) ? idx : spur_idx;
         chk(imem_addr == 8'(s + 8'(c)), "R2", "byte address", imem_addr, 8'(s + 8'(c)));
         @(posedge clk);
         @(negedge clk);
         if (c < 2) begin
            chk(!ifd_valid, "R4", "valid low mid-stage", ifd_valid, 0);
            chk(ifd_word == prev_word, "R5", "word held", ifd_word, prev_word);
         end
      end
      redir_valid = 1'b0;
      chk(ifd_valid, "R4", "valid pulse", ifd_valid, 1);
      chk(ifd_word == exp_word(s), redir ? "R8" : "R3", "assembled word",
          ifd_word, exp_word(s));
      prev_word = exp_word(s);
      exp_start = redir ? tgt(idx) : 8'(s + 8'd3);
      if (spur && !redir)
         chk(imem_addr == exp_start, "R7", "early redirect ignored", imem_addr, exp_start);
      else if (redir)
         chk(imem_addr == exp_start, "R6", "redirect target", imem_addr, exp_start);
      else
         chk(imem_addr == exp_start, "R8", "sequential start", imem_addr, exp_start);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
      exp_start = '0;
      prev_word = '0;

      // Reset state
      repeat (3) @(negedge clk);
      chk(imem_addr == 8'd0, "R1", "reset addr", imem_addr, 0);
      chk(!ifd_valid, "R1", "reset valid", ifd_valid, 0);
      chk(ifd_word == 24'd0, "R1", "reset word", ifd_word, 0);
      rst_n = 1'b1;

      // First words in sequence from byte 0 (R1, R3)
      run_stage(1'b0, 8'd0, 1'b0, 8'd0);
      run_stage(1'b0, 8'd0, 1'b0, 8'd0);

      // Redirect to index 0, then back-to-back redirects (R6, R8)
      run_stage(1'b1, 8'd0, 1'b0, 8'd0);
      run_stage(1'b1, 8'd84, 1'b0, 8'd0);
      run_stage(1'b1, 8'd5, 1'b0, 8'd0);

      // Early redirect requests are ignored (R7)
      run_stage(1'b0, 8'd0, 1'b1, 8'd70);
      run_stage(1'b1, 8'd10, 1'b1, 8'd33);

      // Modulo target and wrap of the program counter (R9)
      run_stage(1'b1, 8'd255, 1'b0, 8'd0);
      chk(imem_addr == 8'd253, "R9", "target mod 256", imem_addr, 253);
      run_stage(1'b0, 8'd0, 1'b0, 8'd0);
      chk(imem_addr == 8'd0, "R9", "wrap to zero", imem_addr, 0);
      run_stage(1'b1, 8'd171, 1'b0, 8'd0);
      chk(imem_addr == 8'd1, "R9", "target 171 wraps", imem_addr, 1);
      run_stage(1'b0, 8'd0, 1'b0, 8'd0);

      // Reset in mid-stage restarts sequencing (R1)
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(imem_addr == 8'd0, "R1", "mid reset addr", imem_addr, 0);
      chk(!ifd_valid, "R1", "mid reset valid", ifd_valid, 0);
      chk(ifd_word == 24'd0, "R1", "mid reset word", ifd_word, 0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_start = '0;
      prev_word = '0;
      run_stage(1'b0, 8'd0, 1'b0, 8'd0);

      // Random mix
      for (int n = 0; n < 400; n++) begin
         bit         r;
         bit         sp;
         logic [7:0] idx;
         logic [7:0] nxt;
         r   = ($urandom % 4) == 0;
         sp  = ($urandom % 5) == 0;
         nxt = 8'(exp_start + 8'd3);
         if (nxt > 8'd253) r = 1'b1;
         idx = 8'($urandom);
         while (tgt(idx) > 8'd253) idx = 8'($urandom);
         run_stage(r, idx, sp, 8'($urandom));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule